// File: doc/BRIEF.md
# Programmable Down-Count Timer with APB Access

This block is a single 32-bit countdown timer sitting behind an APB slave port and driving one interrupt line. Software programs a start value, picks a reload behaviour, and turns the counter on. From then on the counter loses one per clock. When it runs out it reloads itself and flags an event. In periodic mode the reload is the programmed value. In free-running mode the reload is all ones, so the inverted count reads as a time base that rises steadily.

The event is held in a pending flag. Software can read that flag raw, or through a mask bit as the interrupt status. Reading either end-of-interrupt location returns zero and clears the flag. To change the period, software turns the timer off, writes the new start value and turns it on again. The counter only picks up the start value when the enable bit goes from 0 to 1. A fixed identification word can be read at its own offset.

Top module: `apb_down_timer`

## Requirements
- R1: After reset the start-value register, the control register, the counter and the pending flag are all zero, and `irq` is low.
- R2: Every access completes in one access phase with `pready` high and `pslverr` low. Reads return the start value at 0x00, the counter at 0x04 and the control bits in [2:0] at 0x08. Any unmapped offset reads as zero.
- R3: The counter takes the start value on the first clock after the enable bit (control bit 0) goes from 0 to 1. A start value written while the timer stays enabled does not change the counter until the next such edge.
- R4: While enabled, the counter drops by one every clock. While disabled, it holds its value and no event occurs.
- R5: An event happens on the clock where an enabled counter at 1 (or 0) reloads. With control bit 1 = 1 (periodic), the reload is the start value.
- R6: With control bit 1 = 0 (free-running), the reload is 0xFFFF_FFFF.
- R7: An event sets the pending flag. The flag reads in bit 0 of 0xA8. Bit 0 of both 0x10 and 0xA0 reads the flag AND NOT the mask. `irq` matches that masked value.
- R8: With control bit 2 = 1 (mask), `irq` and the masked status stay low while the raw flag still sets.
- R9: A read of 0x0C or 0xA4 returns zero and clears the pending flag. Reads of 0x10, 0xA0 and 0xA8 leave the flag unchanged.
- R10: If a clearing read lands on the same clock as an event, the flag ends up set.
- R11: Offset 0xAC reads the constant given by the `VERSION` parameter.
- R12: Writes to 0x04, 0x10, 0xA0, 0xA8 and 0xAC change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte offset of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while selected for a read |
| pready | output | 1 | Always high, no wait states |
| pslverr | output | 1 | Always low |
| irq | output | 1 | Masked pending event |

## Verification
Every clock, the bound checker verifies the following:
- The counter holds while disabled and decrements while running.
- The counter loads the start value on an enable edge.
- Each mode reloads its own value.
- Every rise of the pending flag comes from an event.
- A clearing read with no coincident event leaves the flag low.
- `irq` is never high under the mask.

Some behaviours only the bench scenarios can show. These are the register read values, the exact clock of expiry counted from the enabling write, and the fact that writes to read-only offsets and status reads have no effect. The bench also shows that a start value written mid-run only takes hold at the next enable edge, and that an event wins over a clearing read on the same clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int TW = 32;
  localparam int AW = 8;
  typedef logic [TW-1:0] word_t;

  localparam logic [AW-1:0] OFS_LOAD  = 8'h00;
  localparam logic [AW-1:0] OFS_CUR   = 8'h04;
  localparam logic [AW-1:0] OFS_CTRL  = 8'h08;
  localparam logic [AW-1:0] OFS_EOI   = 8'h0C;
  localparam logic [AW-1:0] OFS_STAT  = 8'h10;
  localparam logic [AW-1:0] OFS_GSTAT = 8'hA0;
  localparam logic [AW-1:0] OFS_GEOI  = 8'hA4;
  localparam logic [AW-1:0] OFS_RAW   = 8'hA8;
  localparam logic [AW-1:0] OFS_VER   = 8'hAC;

  localparam int CB_EN  = 0;
  localparam int CB_PER = 1;
  localparam int CB_MSK = 2;

  // value the counter takes after running out
  function automatic word_t reload_val(input logic per, input word_t ld);
    return per ? ld : '1;
  endfunction

  // counter is on its last tick
  function automatic logic at_end(input word_t c);
    return c <= word_t'(1);
  endfunction
endpackage

// File: rtl/tmr_regfile.sv
module tmr_regfile
  import tmr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_load,
  input  logic  wr_ctrl,
  input  word_t wdata,
  output word_t load_q,
  output logic  en,
  output logic  per,
  output logic  msk
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
      en     <= 1'b0;
      per    <= 1'b0;
      msk    <= 1'b0;
    end else begin
      if (wr_load) load_q <= wdata;
      if (wr_ctrl) begin
        en  <= wdata[CB_EN];
        per <= wdata[CB_PER];
        msk <= wdata[CB_MSK];
      end
    end
  end
endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  per,
  input  word_t load_q,
  output word_t count,
  output logic  start,
  output logic  expire
);
  logic en_prev;

  assign start  = en & ~en_prev;
  assign expire = en & en_prev & at_end(count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      en_prev <= 1'b0;
    end else begin
      en_prev <= en;
      if (start)       count <= load_q;
      else if (expire) count <= reload_val(per, load_q);
      else if (en)     count <= count - word_t'(1);
    end
  end
endmodule

// File: rtl/tmr_intr.sv
module tmr_intr (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clr,
  input  logic msk,
  output logic raw,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      raw <= 1'b0;
    else if (expire) raw <= 1'b1;
    else if (clr)    raw <= 1'b0;
  end

  assign irq = raw & ~msk;
endmodule

// File: rtl/apb_down_timer.sv
module apb_down_timer
  import tmr_pkg::*;
#(
  parameter logic [TW-1:0] VERSION = 32'h0001_0200
) (
  input  logic          pclk,
  input  logic          presetn,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [TW-1:0] pwdata,
  output logic [TW-1:0] prdata,
  output logic          pready,
  output logic          pslverr,
  output logic          irq
);
  logic  acc_w, wr_w, rd_w;
  logic  en_w, per_w, msk_w;
  word_t load_w, cnt_w;
  logic  start_w, expire_w, raw_w, eoi_rd_w;

  assign acc_w    = psel & penable;
  assign wr_w     = acc_w & pwrite;
  assign rd_w     = acc_w & ~pwrite;
  assign eoi_rd_w = rd_w & ((paddr == OFS_EOI) | (paddr == OFS_GEOI));

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  tmr_regfile u_regs (
    .clk(pclk), .rst_n(presetn),
    .wr_load(wr_w & (paddr == OFS_LOAD)),
    .wr_ctrl(wr_w & (paddr == OFS_CTRL)),
    .wdata(pwdata), .load_q(load_w),
    .en(en_w), .per(per_w), .msk(msk_w)
  );

  tmr_count u_cnt (
    .clk(pclk), .rst_n(presetn), .en(en_w), .per(per_w),
    .load_q(load_w), .count(cnt_w), .start(start_w), .expire(expire_w)
  );

  tmr_intr u_int (
    .clk(pclk), .rst_n(presetn), .expire(expire_w), .clr(eoi_rd_w),
    .msk(msk_w), .raw(raw_w), .irq(irq)
  );

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      case (paddr)
        OFS_LOAD:           prdata = load_w;
        OFS_CUR:            prdata = cnt_w;
        OFS_CTRL:           prdata = word_t'({msk_w, per_w, en_w});
        OFS_STAT, OFS_GSTAT: prdata = word_t'(irq);
        OFS_RAW:            prdata = word_t'(raw_w);
        OFS_VER:            prdata = VERSION;
        default:            prdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
  import tmr_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  en,
  input logic  per,
  input logic  msk,
  input word_t load,
  input word_t count,
  input logic  start,
  input logic  expire,
  input logic  raw,
  input logic  irq,
  input logic  eoi_rd
);
  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(count));
  // R3
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> count == $past(load));
  // R4
  dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !start && !expire) |=> count == $past(count) - word_t'(1));
  // R5
  per_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && per) |=> count == $past(load));
  // R6
  free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !per) |=> count == '1);
  // R10
  set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> raw);
  // R7
  rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw) |-> $past(expire));
  // R9
  clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_rd && !expire) |=> !raw);
  // R8
  msk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (raw && !msk));
endmodule

bind apb_down_timer tmr_chk u_chk (
  .clk(pclk), .rst_n(presetn), .en(en_w), .per(per_w), .msk(msk_w),
  .load(load_w), .count(cnt_w), .start(start_w), .expire(expire_w),
  .raw(raw_w), .irq(irq), .eoi_rd(eoi_rd_w)
);

// File: tb/sim_apb_down_timer.sv
`timescale 1ns/1ps
module sim_apb_down_timer;
  localparam logic [31:0] VER = 32'h0001_0200;
  localparam logic [7:0] A_LOAD = 8'h00, A_CUR = 8'h04, A_CTRL = 8'h08,
                         A_EOI = 8'h0C, A_STAT = 8'h10, A_GSTAT = 8'hA0,
                         A_GEOI = 8'hA4, A_RAW = 8'hA8, A_VER = 8'hAC;
  // {start value, periodic, mask}
  localparam logic [33:0] VEC [4] = '{
    {32'd24, 1'b1, 1'b0},
    {32'd30, 1'b0, 1'b0},
    {32'd40, 1'b1, 1'b1},
    {32'd20, 1'b0, 1'b1}
  };

  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr, irq;
  int          n_chk = 0, n_bad = 0;
  logic [31:0] rd;

  always #2 pclk = ~pclk;

  apb_down_timer #(.VERSION(VER)) u0 (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // tasks start and end at a falling edge
  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge pclk) penable = 1'b1;
    @(negedge pclk) begin psel = 1'b0; penable = 1'b0; pwrite = 1'b0; end
  endtask

  task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge pclk) penable = 1'b1;
    #1 d = prdata;
    @(negedge pclk) begin psel = 1'b0; penable = 1'b0; end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge pclk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge pclk);
    @(negedge pclk) presetn = 1'b1;

    // reset state and fixed reads
    check("R1 irq", {31'b0, irq}, 32'd0);
    check("R2 pready", {31'b0, pready}, 32'd1);
    check("R2 pslverr", {31'b0, pslverr}, 32'd0);
    apb_rd(A_LOAD, rd); check("R1 load", rd, 32'd0);
    apb_rd(A_CTRL, rd); check("R1 ctrl", rd, 32'd0);
    apb_rd(A_CUR, rd);  check("R1 count", rd, 32'd0);
    apb_rd(A_RAW, rd);  check("R1 raw", rd, 32'd0);
    apb_rd(A_VER, rd);  check("R11 version", rd, VER);
    apb_rd(8'h40, rd);  check("R2 unmapped", rd, 32'd0);
    apb_rd(8'h14, rd);  check("R2 unmapped", rd, 32'd0);

    // R12: read-only offsets ignore writes
    apb_wr(A_CUR, 32'h1234);
    apb_wr(A_RAW, 32'h1);
    apb_wr(A_STAT, 32'h1);
    apb_wr(A_GSTAT, 32'h1);
    apb_wr(A_VER, 32'h0);
    apb_rd(A_CUR, rd);  check("R12 count", rd, 32'd0);
    apb_rd(A_RAW, rd);  check("R12 raw", rd, 32'd0);
    apb_rd(A_VER, rd);  check("R12 version", rd, VER);

    // table of mode vectors
    for (int i = 0; i < 4; i++) begin
      logic [31:0] ld, rl;
      logic pe, mk;
      ld = VEC[i][33:2]; pe = VEC[i][1]; mk = VEC[i][0];
      rl = pe ? ld : 32'hFFFF_FFFF;
      apb_wr(A_CTRL, 32'd0);
      apb_rd(A_EOI, rd);
      apb_wr(A_LOAD, ld);
      apb_wr(A_CTRL, {29'd0, mk, pe, 1'b1});
      apb_rd(A_CTRL, rd); check("R2 ctrl readback", rd, {29'd0, mk, pe, 1'b1});
      // the read above took two clocks of the countdown
      repeat (ld - 2) @(posedge pclk);
      @(negedge pclk);
      check("R4 no early event", {31'b0, irq}, 32'd0);
      @(posedge pclk); @(negedge pclk);
      check("R7 R8 irq at expiry", {31'b0, irq}, {31'b0, ~mk});
      apb_rd(A_CUR, rd);
      check(pe ? "R5 periodic reload" : "R6 free reload", rd, rl - 32'd1);
      apb_rd(A_STAT, rd);  check("R8 status", rd, {31'b0, ~mk});
      apb_rd(A_GSTAT, rd); check("R8 global status", rd, {31'b0, ~mk});
      apb_rd(A_RAW, rd);   check("R9 raw kept by status reads", rd, 32'd1);
      apb_rd(i[0] ? A_GEOI : A_EOI, rd); check("R9 eoi data", rd, 32'd0);
      apb_rd(A_RAW, rd);   check("R9 raw cleared", rd, 32'd0);
    end

    // R3 and R4: mid-run start value, hold while disabled
    apb_wr(A_CTRL, 32'd0);
    apb_rd(A_EOI, rd);
    apb_wr(A_LOAD, 32'd1000);
    apb_wr(A_CTRL, 32'd3);
    apb_rd(A_CUR, rd);  check("R3 loaded on enable", rd, 32'd1000);
    apb_wr(A_LOAD, 32'd5);
    apb_rd(A_CUR, rd);  check("R3 R4 mid-run load ignored", rd, 32'd996);
    apb_wr(A_CTRL, 32'd2);
    apb_rd(A_CUR, rd);  check("R4 hold", rd, 32'd993);
    repeat (10) @(negedge pclk);
    apb_rd(A_CUR, rd);  check("R4 hold later", rd, 32'd993);
    check("R4 no event when off", {31'b0, irq}, 32'd0);
    apb_wr(A_CTRL, 32'd3);
    apb_rd(A_CUR, rd);  check("R3 new value on next edge", rd, 32'd5);

    // R10: clearing read on the expiry clock
    apb_wr(A_CTRL, 32'd0);
    apb_rd(A_EOI, rd);
    apb_rd(A_RAW, rd);  check("R9 cleared before collision", rd, 32'd0);
    apb_wr(A_LOAD, 32'd1);
    apb_wr(A_CTRL, 32'd1);
    apb_rd(A_EOI, rd);
    apb_rd(A_RAW, rd);  check("R10 set wins", rd, 32'd1);
    check("R10 irq", {31'b0, irq}, 32'd1);
    apb_rd(A_CUR, rd);  check("R6 free count", rd, 32'hFFFF_FFFC);

    finish_run();
  end
endmodule